// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns parallel characters written by a host into an asynchronous serial frame on one output line. Each frame begins with one low start bit. The data bits follow, least significant bit first. An optional parity bit comes next, and the frame ends with a high stop period. The character length, the parity mode and the stop length are set at run time through static configuration inputs. All bit timing comes from a 16x oversampling enable, `baudTick`, which an external rate divider supplies. Every bit lasts a fixed number of these enables.

A one-character holding register takes the host write. When the framing engine is free, the character moves from the holding register into a shift register. The host can therefore write the next character while the current one is still on the line. Three flags report the state of the block to the host: holding register empty, transmitter fully empty, and a sticky overrun for writes that arrive while the holding register is full.

Two line overrides are provided. A break control forces the line low. A loopback control parks the external pin at the marking level and sends the serial stream to a tap that a receiver can read.

Top module: `ser_tx_framer`

## Requirements
- R1: After reset, `txPin` and `loopTap` are high, `holdEmpty` and `txEmpty` are 1 and `overrun` is 0. While the transmitter is empty and neither override is active, `txPin` is high.
- R2: A frame is one low start bit followed by the data bits, least significant first. `charLen` selects the data bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Every start, data and parity bit lasts 16 `baudTick` enables.
- R3: When `parityEn` is 1, one parity bit follows the last data bit. It is computed over the selected data bits only. With `parityOdd` = 0 the total count of ones is even; with `parityOdd` = 1 it is odd.
- R4: The stop period is high. It lasts 16 enables when `stopLong` = 0. When `stopLong` = 1 it lasts 24 enables with `charLen` = 00 and 32 enables otherwise. `txEmpty` rises on the edge that ends the stop period when no character is waiting.
- R5: While `breakCtl` is 1 and `loopEn` is 0, `txPin` is low. The frame in progress keeps its timing underneath, and the line shows the normal bits again once the break is released.
- R6: While `loopEn` is 1, `txPin` stays high and `loopTap` carries the serial stream, including any break. While `loopEn` is 0, `loopTap` stays high.
- R7: An accepted write clears `holdEmpty` on the next edge. `holdEmpty` sets on the edge where the character moves into the shift register, which is also the edge where its start bit begins. `txEmpty` is 1 only when both registers are empty.
- R8: A character that is waiting when a stop period ends starts its start bit on that same edge, with no idle gap.
- R9: A write while `holdEmpty` is 0 is discarded. The held character is the one sent, and `overrun` becomes 1 and stays 1 until reset.
- R10: Without `baudTick` enables the frame makes no progress. The line holds its current bit until enables resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | 16x bit-rate enable, one cycle per pulse |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Character to send |
| charLen | input | 2 | Data bit count code (5 to 8) |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | Odd parity when 1, even when 0 |
| stopLong | input | 1 | Long stop period (1.5 or 2 bits) |
| breakCtl | input | 1 | Force the line to spacing |
| loopEn | input | 1 | Divert the stream to the loopback tap |
| txPin | output | 1 | Serial output line |
| loopTap | output | 1 | Receiver-facing loopback stream |
| holdEmpty | output | 1 | Holding register is free |
| txEmpty | output | 1 | Holding and shift registers both empty |
| overrun | output | 1 | Sticky flag for a discarded write |

## Verification
The case that is hardest to reach from the ports is a full holding register at the exact edge where a stop period ends. A second write must also land in that same window so that it is discarded. The stimulus starts an 8-bit frame, writes a second character early in that frame, and then writes a third character before the first frame ends. The bench then counts cycles to the stop boundary. There it checks that the second character starts with no gap, that its bits belong to the second write and not the third, and that no third frame follows. Separate directed cases stop the enables mid-bit and raise break mid-frame, to show that the underlying timing is preserved.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DATA_W = 8;
  localparam int MIN_LEN = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  typedef struct packed {
    logic loadShift;
    logic shiftBit;
  } txStrobe_t;

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baudTick,
  input  logic       holdFull,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       stopLong,
  output txStrobe_t  strobe,
  output txState_t   state
);

  localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);
  localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(OVERSAMPLE);
  localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2);
  localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * OVERSAMPLE);

  txState_t stateNext;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] bitLimit;
  logic [2:0] bitIdx;
  logic [2:0] lastIdx;
  logic bitEnd;

  // Length of the current bit in enables; the stop period stretches
  always_comb begin
    bitLimit = LIM_ONE;
    if (state == ST_STOP && stopLong) begin
      bitLimit = (charLen == 2'b00) ? LIM_HALF : LIM_TWO;
    end
  end

  assign lastIdx = 3'(MIN_LEN - 1) + {1'b0, charLen};
  assign bitEnd  = baudTick && (tickCnt == bitLimit - 1'b1);

  always_comb begin
    stateNext        = state;
    strobe.loadShift = 1'b0;
    strobe.shiftBit  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (holdFull) begin
          strobe.loadShift = 1'b1;
          stateNext        = ST_START;
        end
      end
      ST_START: begin
        if (bitEnd) stateNext = ST_DATA;
      end
      ST_DATA: begin
        if (bitEnd) begin
          strobe.shiftBit = 1'b1;
          if (bitIdx == lastIdx) stateNext = parityEn ? ST_PARITY : ST_STOP;
        end
      end
      ST_PARITY: begin
        if (bitEnd) stateNext = ST_STOP;
      end
      ST_STOP: begin
        if (bitEnd) begin
          if (holdFull) begin
            strobe.loadShift = 1'b1;
            stateNext        = ST_START;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state <= stateNext;
      if (strobe.loadShift || bitEnd) begin
        tickCnt <= '0;
      end else if (baudTick && state != ST_IDLE) begin
        tickCnt <= tickCnt + 1'b1;
      end
      if (state != ST_DATA) begin
        bitIdx <= '0;
      end else if (strobe.shiftBit) begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sertx_dpath.sv
module sertx_dpath
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  txStrobe_t         strobe,
  input  txState_t          state,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        charLen,
  input  logic              parityOdd,
  input  logic              breakCtl,
  input  logic              loopEn,
  output logic              holdFull,
  output logic              overrun,
  output logic              txPin,
  output logic              loopTap
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lenMask;
  logic parityBit;
  logic serialBit;
  logic streamBit;

  // Keep only the selected data bits for the parity sum
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      lenMask[i] = (i < MIN_LEN + int'(charLen));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (wrEn) begin
        if (holdFull) begin
          overrun <= 1'b1;
        end else begin
          holdReg  <= wrData;
          holdFull <= 1'b1;
        end
      end
      if (strobe.loadShift) holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else if (strobe.loadShift) begin
      shiftReg  <= holdReg;
      parityBit <= (^(holdReg & lenMask)) ^ parityOdd;
    end else if (strobe.shiftBit) begin
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (state)
      ST_START:  serialBit = 1'b0;
      ST_DATA:   serialBit = shiftReg[0];
      ST_PARITY: serialBit = parityBit;
      default:   serialBit = 1'b1;
    endcase
  end

  assign streamBit = breakCtl ? 1'b0 : serialBit;
  assign txPin     = loopEn ? 1'b1 : streamBit;
  assign loopTap   = loopEn ? streamBit : 1'b1;

endmodule

// File: rtl/ser_tx_framer.sv
module ser_tx_framer
  import sertx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baudTick,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       stopLong,
  input  logic       breakCtl,
  input  logic       loopEn,
  output logic       txPin,
  output logic       loopTap,
  output logic       holdEmpty,
  output logic       txEmpty,
  output logic       overrun
);

  txStrobe_t strobe;
  txState_t  state;
  logic      holdFull;

  sertx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .baudTick (baudTick),
    .holdFull (holdFull),
    .charLen  (charLen),
    .parityEn (parityEn),
    .stopLong (stopLong),
    .strobe   (strobe),
    .state    (state)
  );

  sertx_dpath u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .state     (state),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .charLen   (charLen),
    .parityOdd (parityOdd),
    .breakCtl  (breakCtl),
    .loopEn    (loopEn),
    .holdFull  (holdFull),
    .overrun   (overrun),
    .txPin     (txPin),
    .loopTap   (loopTap)
  );

  assign holdEmpty = !holdFull;
  assign txEmpty   = !holdFull && (state == ST_IDLE);

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
  input logic clk,
  input logic rst_n,
  input logic wrEn,
  input logic breakCtl,
  input logic loopEn,
  input logic txPin,
  input logic holdEmpty,
  input logic txEmpty,
  input logic overrun
);

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (txEmpty && !breakCtl && !loopEn) |-> txPin);

  assert_break_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (breakCtl && !loopEn) |-> !txPin);

  assert_loop_pin_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loopEn |-> txPin);

  assert_empty_implies_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    txEmpty |-> holdEmpty);

  assert_hold_free_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdEmpty) |-> !txEmpty);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(wrEn && !holdEmpty));

endmodule

bind ser_tx_framer sertx_checker u_chk (.*);

// File: tb/tb_ser_tx_framer.sv
module tb_ser_tx_framer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baudTick = 1'b1;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] charLen = 2'd3;
  logic parityEn = 1'b0;
  logic parityOdd = 1'b0;
  logic stopLong = 1'b0;
  logic breakCtl = 1'b0;
  logic loopEn = 1'b0;
  logic txPin, loopTap, holdEmpty, txEmpty, overrun;

  int checks = 0;
  int errors = 0;
  int off = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ser_tx_framer dut (.*);

  // {data, charLen, parityEn, parityOdd, stopLong}
  localparam logic [12:0] VEC [8] = '{
    {8'h55, 2'd3, 1'b0, 1'b0, 1'b0},
    {8'hA3, 2'd3, 1'b1, 1'b0, 1'b0},
    {8'hA3, 2'd3, 1'b1, 1'b1, 1'b1},
    {8'h1F, 2'd0, 1'b0, 1'b0, 1'b1},
    {8'hF6, 2'd0, 1'b1, 1'b0, 1'b0},
    {8'h2C, 2'd1, 1'b1, 1'b1, 1'b1},
    {8'h7E, 2'd2, 1'b0, 1'b0, 1'b1},
    {8'hC1, 2'd2, 1'b1, 1'b1, 1'b0}
  };

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic stepTo(input int target);
    while (off < target) begin
      @(negedge clk);
      off++;
    end
  endtask

  task automatic writeChar(input logic [7:0] d);
    wrEn   = 1'b1;
    wrData = d;
    @(negedge clk);
    off++;
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 600 && !txEmpty; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic lineIs(input logic useLoop, input logic exp, input string tag);
    if (useLoop) begin
      checkEq(tag, loopTap, exp);
      checkEq("R6 pin parked high in loopback", txPin, 1'b1);
    end else begin
      checkEq(tag, txPin, exp);
      checkEq("R6 tap high without loopback", loopTap, 1'b1);
    end
  endtask

  task automatic runFrame(input logic [7:0] d, input logic [1:0] len, input logic pe,
                          input logic po, input logic sl, input logic useLoop);
    int n, nb, stopLen;
    logic par;
    n = 5 + int'(len);
    par = po;
    for (int i = 0; i < n; i++) par ^= d[i];
    nb = 1 + n + (pe ? 1 : 0);
    stopLen = sl ? ((len == 2'd0) ? 24 : 32) : 16;
    charLen = len; parityEn = pe; parityOdd = po; stopLong = sl; loopEn = useLoop;
    writeChar(d);
    checkEq("R7 holdEmpty cleared after write", holdEmpty, 1'b0);
    @(negedge clk);
    off = 0;
    checkEq("R7 holdEmpty set at load", holdEmpty, 1'b1);
    checkEq("R7 txEmpty low while shifting", txEmpty, 1'b0);
    lineIs(useLoop, 1'b0, "R2 start bit begins");
    stepTo(15);
    lineIs(useLoop, 1'b0, "R2 start bit end");
    for (int i = 0; i < n; i++) begin
      stepTo(16 * (i + 1) + 8);
      lineIs(useLoop, d[i], "R2 data bit");
    end
    if (pe) begin
      stepTo(16 * (n + 1) + 8);
      lineIs(useLoop, par, "R3 parity bit");
    end
    stepTo(16 * nb);
    lineIs(useLoop, 1'b1, "R4 stop begins");
    stepTo(16 * nb + stopLen - 1);
    lineIs(useLoop, 1'b1, "R4 stop last cycle");
    checkEq("R4 txEmpty low within stop", txEmpty, 1'b0);
    stepTo(16 * nb + stopLen);
    checkEq("R4 txEmpty after stop", txEmpty, 1'b1);
    loopEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R1 reset txPin", txPin, 1'b1);
    checkEq("R1 reset loopTap", loopTap, 1'b1);
    checkEq("R1 reset holdEmpty", holdEmpty, 1'b1);
    checkEq("R1 reset txEmpty", txEmpty, 1'b1);
    checkEq("R1 reset overrun", overrun, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R1 idle line high", txPin, 1'b1);

    for (int v = 0; v < 8; v++) begin
      runFrame(VEC[v][12:5], VEC[v][4:3], VEC[v][2], VEC[v][1], VEC[v][0], 1'b0);
    end

    // R6 loopback frame
    runFrame(8'h96, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1);

    // R8 and R9: back-to-back characters and a discarded write
    charLen = 2'd3; parityEn = 1'b0; stopLong = 1'b0;
    writeChar(8'h3C);
    @(negedge clk);
    off = 0;
    stepTo(20);
    writeChar(8'hA5);
    checkEq("R7 holdEmpty low with char waiting", holdEmpty, 1'b0);
    checkEq("R7 txEmpty low with char waiting", txEmpty, 1'b0);
    stepTo(25);
    writeChar(8'hFF);
    checkEq("R9 overrun raised", overrun, 1'b1);
    stepTo(159);
    checkEq("R8 first stop last cycle", txPin, 1'b1);
    checkEq("R7 still held before boundary", holdEmpty, 1'b0);
    stepTo(160);
    checkEq("R8 next start without gap", txPin, 1'b0);
    checkEq("R7 holdEmpty at move", holdEmpty, 1'b1);
    for (int i = 0; i < 8; i++) begin
      stepTo(160 + 16 * (i + 1) + 8);
      checkEq("R9 held char sent not discarded one", txPin, 8'hA5 >> i & 8'h01);
    end
    stepTo(319);
    checkEq("R9 no third frame pending", txEmpty, 1'b0);
    stepTo(320);
    checkEq("R9 no third frame", txEmpty, 1'b1);
    checkEq("R9 overrun sticky", overrun, 1'b1);
    @(negedge clk);

    // R5 break while idle and mid-frame
    breakCtl = 1'b1;
    @(negedge clk);
    checkEq("R5 break forces low at idle", txPin, 1'b0);
    breakCtl = 1'b0;
    @(negedge clk);
    checkEq("R5 break release idle", txPin, 1'b1);
    writeChar(8'h0F);
    @(negedge clk);
    off = 0;
    stepTo(20);
    breakCtl = 1'b1;
    stepTo(24);
    checkEq("R5 break over mark data bit", txPin, 1'b0);
    stepTo(30);
    breakCtl = 1'b0;
    stepTo(40);
    checkEq("R5 bit1 after break", txPin, 1'b1);
    stepTo(72);
    checkEq("R5 bit3 timing kept", txPin, 1'b1);
    stepTo(88);
    checkEq("R5 bit4 timing kept", txPin, 1'b0);
    waitIdle();

    // R10 no enables means no progress
    baudTick = 1'b0;
    writeChar(8'h01);
    @(negedge clk);
    off = 0;
    checkEq("R10 start entered without enables", txPin, 1'b0);
    stepTo(50);
    checkEq("R10 start held", txPin, 1'b0);
    checkEq("R10 still busy", txEmpty, 1'b0);
    baudTick = 1'b1;
    stepTo(65);
    checkEq("R10 start resumes full length", txPin, 1'b0);
    stepTo(74);
    checkEq("R10 first data bit after resume", txPin, 1'b1);
    waitIdle();

    // R9 overrun clears only through reset
    rst_n = 1'b0;
    @(negedge clk);
    checkEq("R9 overrun cleared by reset", overrun, 1'b0);
    checkEq("R1 holdEmpty after reset", holdEmpty, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule